// File: doc/BRIEF.md
# UART Line and Modem Status Word

This block gathers the state of a UART receiver, transmitter and flow-control line into one 32-bit status word that software reads over a simple register port. Receiver events arrive as one-cycle pulses: overrun, parity error, framing error, break, and the end of each received word with an address/data marker. Transmitter state arrives as levels, together with a pulse when a transmission completes. The raw clear-to-send pin enters through a synchronizer. Some bits are sticky and cleared by writing a one. One bit is set by writing a one. The rest follow live hardware state.

A live fill-level flag compares the receive FIFO occupancy with one of two thresholds, picked by a control input. It drives a level interrupt when enabled. Reading the word never alters any state.

Top module: `uart_line_status`

## Requirements
- R1: After synchronous reset, the status word reads 0x0000_0060: bits 5 (transmit hold empty) and 6 (transmitter fully empty) are set and every other bit is 0.
- R2: A one-cycle pulse on an event input sets its sticky bit at the next clock edge: overrun to bit 1, parity to bit 2, framing to bit 3, break to bit 4, transmission finished to bit 7.
- R3: A write with a 1 in a sticky bit position (bits 1, 2, 3, 4, 7, 8, 17) clears that bit at the next clock edge. Bits written with 0 keep their value.
- R4: When a hardware set event and a write-one-to-clear of the same sticky bit fall in the same cycle, the bit ends up set.
- R5: Reading the word has no side effect. Repeated reads with no event and no write return the same value.
- R6: A received address word sets bit 9 (address status) and bit 8 (address sticky). A received data word clears bit 9. Writing a 1 to bit 9 sets it. Bit 8 is cleared by writing a 1.
- R7: Bits 0 (data ready), 5 (hold register empty), 6 (hold and shift register both empty) and 10 (reception ongoing) show their inputs as registered one clock later. Bit 6 is the AND of the two empty inputs.
- R8: Bit 16 shows the clear-to-send pin after a two-flop synchronizer, two edges after the pin changes. Bit 17 sets on any change of the synchronized level, three edges after the pin changes.
- R9: Bit 18 is a live comparison. It is 1 while the FIFO count is at least 4 with threshold-select 0, or at least 7 with threshold-select 1. Otherwise it is 0.
- R10: The interrupt output is the level of bit 18 AND the interrupt-enable input.
- R11: Bits 11 to 15 and 19 to 31 always read 0. The read data bus is 0 whenever read-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe; gates the read data bus |
| rd_data | output | 32 | Status word when rd_en is high, else 0 |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; ones clear sticky bits or set bit 9 |
| rx_data_ready | input | 1 | Receive data available (level) |
| rx_busy | input | 1 | Reception in progress (level) |
| tx_hold_empty | input | 1 | Transmit hold register empty (level) |
| tx_shift_empty | input | 1 | Transmit shift register empty (level) |
| tx_done | input | 1 | Transmission finished pulse |
| ev_overrun | input | 1 | Overrun pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_framing | input | 1 | Framing error pulse |
| ev_break | input | 1 | Break detected pulse |
| rx_word_done | input | 1 | Pulse for each received word |
| rx_word_is_addr | input | 1 | Received word is an address (valid with rx_word_done) |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| rx_fifo_count | input | 4 | Receive FIFO occupancy |
| thresh_sel | input | 1 | 0: threshold 4, 1: threshold 7 |
| fill_irq_en | input | 1 | Enable for the fill-level interrupt |
| fill_irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 4-bit count, which reaches counts up to 15 on both sides of both thresholds, and thresholds of 4 and 7 with a two-stage synchronizer. With these values both threshold boundaries can be reached exactly, and the clear-to-send latency of two and three edges can be checked cycle by cycle. The set-versus-clear collision, the address bit going set, cleared and set by write, and bulk writes that clear many bits at once are all within reach of short directed sequences.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

    localparam int WORD_W = 32;

    localparam int B_DR    = 0;
    localparam int B_OE    = 1;
    localparam int B_PE    = 2;
    localparam int B_FE    = 3;
    localparam int B_BI    = 4;
    localparam int B_THRE  = 5;
    localparam int B_TEMT  = 6;
    localparam int B_TFI   = 7;
    localparam int B_ASTKY = 8;
    localparam int B_ADDR  = 9;
    localparam int B_RO    = 10;
    localparam int B_CTS   = 16;
    localparam int B_SCTS  = 17;
    localparam int B_RFCS  = 18;

    // sticky bank ordering
    localparam int N_STICKY = 7;
    localparam int S_OE = 0, S_PE = 1, S_FE = 2, S_BI = 3, S_TFI = 4, S_ASTKY = 5, S_SCTS = 6;

    typedef struct packed {
        logic dr;
        logic thre;
        logic temt;
        logic ro;
    } live_t;

    typedef struct packed {
        logic [N_STICKY-1:0] sticky;
        logic                addr;
        live_t               live;
        logic                cts;
        logic                rfcs;
    } status_t;

    localparam live_t LIVE_RESET = '{dr: 1'b0, thre: 1'b1, temt: 1'b1, ro: 1'b0};

    function automatic logic [WORD_W-1:0] pack_status(input status_t s);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[B_DR]    = s.live.dr;
        w[B_OE]    = s.sticky[S_OE];
        w[B_PE]    = s.sticky[S_PE];
        w[B_FE]    = s.sticky[S_FE];
        w[B_BI]    = s.sticky[S_BI];
        w[B_THRE]  = s.live.thre;
        w[B_TEMT]  = s.live.temt;
        w[B_TFI]   = s.sticky[S_TFI];
        w[B_ASTKY] = s.sticky[S_ASTKY];
        w[B_ADDR]  = s.addr;
        w[B_RO]    = s.live.ro;
        w[B_CTS]   = s.cts;
        w[B_SCTS]  = s.sticky[S_SCTS];
        w[B_RFCS]  = s.rfcs;
        return w;
    endfunction

    function automatic logic [N_STICKY-1:0] sticky_clear_mask(input logic [WORD_W-1:0] d);
        logic [N_STICKY-1:0] m;
        m[S_OE]    = d[B_OE];
        m[S_PE]    = d[B_PE];
        m[S_FE]    = d[B_FE];
        m[S_BI]    = d[B_BI];
        m[S_TFI]   = d[B_TFI];
        m[S_ASTKY] = d[B_ASTKY];
        m[S_SCTS]  = d[B_SCTS];
        return m;
    endfunction

endpackage

// File: rtl/uart_stat_sync.sv
module uart_stat_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic changed
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign level   = chain[STAGES-1];
    assign changed = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/uart_stat_sticky.sv
module uart_stat_sticky #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] q
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)             q[i] <= 1'b0;
                else if (set_vec[i]) q[i] <= 1'b1;   // hardware event beats clear
                else if (clr_vec[i]) q[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/uart_stat_level.sv
module uart_stat_level #(
    parameter int CNT_W  = 4,
    parameter int THR_LO = 4,
    parameter int THR_HI = 7
) (
    input  logic [CNT_W-1:0] count,
    input  logic             sel_hi,
    output logic             at_or_above
);
    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(THR_LO);
    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(THR_HI);

    always_comb begin
        at_or_above = (count >= (sel_hi ? LIM_HI : LIM_LO));
    end
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
    import uart_stat_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int THR_LO      = 4,
    parameter int THR_HI      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rx_data_ready,
    input  logic              rx_busy,
    input  logic              tx_hold_empty,
    input  logic              tx_shift_empty,
    input  logic              tx_done,
    input  logic              ev_overrun,
    input  logic              ev_parity,
    input  logic              ev_framing,
    input  logic              ev_break,
    input  logic              rx_word_done,
    input  logic              rx_word_is_addr,
    input  logic              cts_pin,
    input  logic [CNT_W-1:0]  rx_fifo_count,
    input  logic              thresh_sel,
    input  logic              fill_irq_en,
    output logic              fill_irq
);
    status_t             st;
    live_t               live_q;
    logic                addr_q;
    logic                cts_lvl, cts_chg;
    logic                rfcs;
    logic [N_STICKY-1:0] set_vec, clr_vec, sticky_q;
    logic [WORD_W-1:0]   stat_word;
    logic                addr_word, data_word;
    logic                unused_wr_bits;

    assign unused_wr_bits = ^wr_data;
    assign addr_word = rx_word_done &  rx_word_is_addr;
    assign data_word = rx_word_done & ~rx_word_is_addr;

    uart_stat_sync #(.STAGES(SYNC_STAGES)) u_cts (
        .clk      (clk),
        .rst      (rst),
        .async_in (cts_pin),
        .level    (cts_lvl),
        .changed  (cts_chg)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[S_OE]    = ev_overrun;
        set_vec[S_PE]    = ev_parity;
        set_vec[S_FE]    = ev_framing;
        set_vec[S_BI]    = ev_break;
        set_vec[S_TFI]   = tx_done;
        set_vec[S_ASTKY] = addr_word;
        set_vec[S_SCTS]  = cts_chg;
        clr_vec          = wr_en ? sticky_clear_mask(wr_data) : '0;
    end

    uart_stat_sticky #(.N(N_STICKY)) u_sticky (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .q       (sticky_q)
    );

    uart_stat_level #(.CNT_W(CNT_W), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_level (
        .count       (rx_fifo_count),
        .sel_hi      (thresh_sel),
        .at_or_above (rfcs)
    );

    // live mirrors, one register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= LIVE_RESET;
        end else begin
            live_q.dr   <= rx_data_ready;
            live_q.thre <= tx_hold_empty;
            live_q.temt <= tx_hold_empty & tx_shift_empty;
            live_q.ro   <= rx_busy;
        end
    end

    // address status: set by address word or W1S, cleared by data word
    always_ff @(posedge clk) begin
        if (rst)                               addr_q <= 1'b0;
        else if (addr_word)                    addr_q <= 1'b1;
        else if (wr_en && wr_data[B_ADDR])     addr_q <= 1'b1;
        else if (data_word)                    addr_q <= 1'b0;
    end

    always_comb begin
        st.sticky = sticky_q;
        st.addr   = addr_q;
        st.live   = live_q;
        st.cts    = cts_lvl;
        st.rfcs   = rfcs;
        stat_word = pack_status(st);
    end

    assign rd_data  = rd_en ? stat_word : '0;
    assign fill_irq = rfcs & fill_irq_en;

endmodule

// File: rtl/uart_line_status_chk.sv
module uart_line_status_chk
    import uart_stat_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic              ev_overrun,
    input logic              ev_parity,
    input logic              ev_framing,
    input logic              ev_break,
    input logic              tx_done,
    input logic              rx_word_done,
    input logic              fill_irq,
    input logic              fill_irq_en,
    input logic              thresh_sel,
    input logic [CNT_W-1:0]  rx_fifo_count,
    input logic [WORD_W-1:0] stat
);
    localparam logic [WORD_W-1:0] USED =
        (WORD_W'(1) << B_DR)   | (WORD_W'(1) << B_OE)    | (WORD_W'(1) << B_PE)   |
        (WORD_W'(1) << B_FE)   | (WORD_W'(1) << B_BI)    | (WORD_W'(1) << B_THRE) |
        (WORD_W'(1) << B_TEMT) | (WORD_W'(1) << B_TFI)   | (WORD_W'(1) << B_ASTKY)|
        (WORD_W'(1) << B_ADDR) | (WORD_W'(1) << B_RO)    | (WORD_W'(1) << B_CTS)  |
        (WORD_W'(1) << B_SCTS) | (WORD_W'(1) << B_RFCS);

    AST_EVENT_SETS_OE: assert property (@(posedge clk) disable iff (rst)
        ev_overrun |=> stat[B_OE]);                                          // R2

    AST_W1C_CLEARS_PE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[B_PE] && !ev_parity) |=> !stat[B_PE]);             // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[B_FE] && ev_framing) |=> stat[B_FE]);              // R4

    AST_QUIET_STICKY_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ev_overrun && !ev_parity && !ev_framing && !ev_break && !tx_done && !rx_word_done)
        |=> $stable({stat[B_ASTKY], stat[B_TFI], stat[B_BI], stat[B_FE], stat[B_PE], stat[B_OE]})); // R5

    AST_ADDR_W1S: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[B_ADDR]) |=> stat[B_ADDR]);                        // R6

    AST_FILL_LOW_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
        (!thresh_sel && rx_fifo_count >= CNT_W'(4)) |-> stat[B_RFCS]);       // R9

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        fill_irq |-> (fill_irq_en && stat[B_RFCS]));                         // R10

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (stat & ~USED) == '0);                                               // R11
endmodule

bind uart_line_status uart_line_status_chk #(.CNT_W(CNT_W)) chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .ev_overrun    (ev_overrun),
    .ev_parity     (ev_parity),
    .ev_framing    (ev_framing),
    .ev_break      (ev_break),
    .tx_done       (tx_done),
    .rx_word_done  (rx_word_done),
    .fill_irq      (fill_irq),
    .fill_irq_en   (fill_irq_en),
    .thresh_sel    (thresh_sel),
    .rx_fifo_count (rx_fifo_count),
    .stat          (stat_word)
);

// File: tb/uart_line_status_test.sv
module uart_line_status_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    // {sel, en, count[3:0], exp_rfcs, exp_irq}
    localparam logic [7:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 4'd3,  1'b0, 1'b0},
        {1'b0, 1'b1, 4'd4,  1'b1, 1'b1},
        {1'b0, 1'b0, 4'd5,  1'b1, 1'b0},
        {1'b0, 1'b1, 4'd0,  1'b0, 1'b0},
        {1'b1, 1'b1, 4'd4,  1'b0, 1'b0},
        {1'b1, 1'b1, 4'd6,  1'b0, 1'b0},
        {1'b1, 1'b1, 4'd7,  1'b1, 1'b1},
        {1'b1, 1'b0, 4'd7,  1'b1, 1'b0},
        {1'b1, 1'b1, 4'd15, 1'b1, 1'b1},
        {1'b0, 1'b1, 4'd15, 1'b1, 1'b1},
        {1'b0, 1'b1, 4'd6,  1'b1, 1'b1}
    };

    logic        clk = 0, rst = 1;
    logic        rd_en = 0, wr_en = 0;
    logic [31:0] rd_data, wr_data = '0;
    logic        rx_data_ready = 0, rx_busy = 0, tx_hold_empty = 1, tx_shift_empty = 1;
    logic        tx_done = 0, ev_overrun = 0, ev_parity = 0, ev_framing = 0, ev_break = 0;
    logic        rx_word_done = 0, rx_word_is_addr = 0, cts_pin = 0;
    logic [3:0]  rx_fifo_count = '0;
    logic        thresh_sel = 0, fill_irq_en = 0, fill_irq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_line_status uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data),
        .rx_data_ready(rx_data_ready), .rx_busy(rx_busy),
        .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
        .tx_done(tx_done), .ev_overrun(ev_overrun), .ev_parity(ev_parity),
        .ev_framing(ev_framing), .ev_break(ev_break),
        .rx_word_done(rx_word_done), .rx_word_is_addr(rx_word_is_addr),
        .cts_pin(cts_pin), .rx_fifo_count(rx_fifo_count),
        .thresh_sel(thresh_sel), .fill_irq_en(fill_irq_en), .fill_irq(fill_irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic read_word(output logic [31:0] w);
        rd_en = 1;
        #1;
        w = rd_data;
        rd_en = 0;
    endtask

    task automatic expect_word(input string req, input logic [31:0] exp);
        logic [31:0] w;
        read_word(w);
        check(req, w, exp);
    endtask

    task automatic write_word(input logic [31:0] d);
        wr_en = 1; wr_data = d;
        tick();
        wr_en = 0; wr_data = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        repeat (3) tick();
        rst = 0;
        tick();

        expect_word("R1 reset value", 32'h0000_0060);
        #1; check("R11 rd_data zero without rd_en", rd_data, 32'h0);

        // R7 live mirrors
        rx_data_ready = 1; rx_busy = 1; tx_hold_empty = 0;
        expect_word("R7 mirrors before edge", 32'h0000_0060);
        tick();
        expect_word("R7 mirrors registered", 32'h0000_0401);
        tx_hold_empty = 1; tx_shift_empty = 0; rx_data_ready = 0; rx_busy = 0;
        tick();
        expect_word("R7 TEMT needs both empty", 32'h0000_0020);
        tx_shift_empty = 1;
        tick();
        expect_word("R7 mirrors restored", 32'h0000_0060);

        // R2 event pulses
        ev_overrun = 1; tick(); ev_overrun = 0;
        expect_word("R2 overrun bit 1", 32'h0000_0062);
        ev_parity = 1; ev_framing = 1; ev_break = 1; tx_done = 1;
        tick();
        ev_parity = 0; ev_framing = 0; ev_break = 0; tx_done = 0;
        expect_word("R2 all sticky events", 32'h0000_00FE);

        // R5 reads have no side effect
        read_word(a); tick(); read_word(b);
        check("R5 repeated read", b, a);
        check("R5 value kept", b, 32'h0000_00FE);

        // R3 W1C
        write_word(32'h0);
        expect_word("R3 write zero keeps bits", 32'h0000_00FE);
        write_word(32'h0000_0004);
        expect_word("R3 clear parity only", 32'h0000_00FA);
        write_word(32'h0000_01FB);
        expect_word("R3 bulk clear", 32'h0000_0060);

        // R4 set beats clear
        wr_en = 1; wr_data = 32'h0000_0002; ev_overrun = 1;
        tick();
        wr_en = 0; wr_data = '0; ev_overrun = 0;
        expect_word("R4 set wins", 32'h0000_0062);
        write_word(32'h0000_0002);
        expect_word("R4 cleared after", 32'h0000_0060);

        // R6 address bits
        rx_word_done = 1; rx_word_is_addr = 1; tick(); rx_word_done = 0; rx_word_is_addr = 0;
        expect_word("R6 address word", 32'h0000_0360);
        rx_word_done = 1; tick(); rx_word_done = 0;
        expect_word("R6 data word clears addr", 32'h0000_0160);
        write_word(32'h0000_0100);
        expect_word("R6 astky W1C", 32'h0000_0060);
        write_word(32'h0000_0200);
        expect_word("R6 addr W1S", 32'h0000_0260);
        rx_word_done = 1; tick(); rx_word_done = 0;
        expect_word("R6 addr cleared by data", 32'h0000_0060);

        // R8 CTS synchronizer and sticky change
        cts_pin = 1;
        tick(); expect_word("R8 cts after one edge", 32'h0000_0060);
        tick(); expect_word("R8 cts after two edges", 32'h0001_0060);
        tick(); expect_word("R8 sticky cts after three", 32'h0003_0060);
        write_word(32'h0002_0000);
        expect_word("R8 sticky cts W1C", 32'h0001_0060);
        cts_pin = 0;
        repeat (3) tick();
        expect_word("R8 falling change", 32'h0002_0060);
        write_word(32'h0002_0000);
        expect_word("R8 cleared", 32'h0000_0060);

        // R9/R10 vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] w;
            thresh_sel    = VEC[i][7];
            fill_irq_en   = VEC[i][6];
            rx_fifo_count = VEC[i][5:2];
            tick();
            read_word(w);
            check($sformatf("R9 fill flag vec %0d", i), {31'b0, w[18]}, {31'b0, VEC[i][1]});
            check($sformatf("R10 irq vec %0d", i), {31'b0, fill_irq}, {31'b0, VEC[i][0]});
        end

        // R9 live drain below threshold
        thresh_sel = 0; fill_irq_en = 1; rx_fifo_count = 4'd4;
        #1; expect_word("R9 at threshold 4", 32'h0004_0060);
        rx_fifo_count = 4'd3;
        #1; expect_word("R9 drained below", 32'h0000_0060);
        check("R10 irq drops", {31'b0, fill_irq}, 32'h0);
        rx_fifo_count = 4'd0; fill_irq_en = 0;
        tick();

        // R1 reset again restores
        ev_parity = 1; tick(); ev_parity = 0;
        rst = 1; tick(); rst = 0;
        expect_word("R1 reset clears sticky", 32'h0000_0060);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule